// File: doc/BRIEF.md
# USB Endpoint Interrupt Status Register

This block holds one sticky interrupt flag for each transfer direction of a small USB device controller. The first two flags belong to control endpoint 0, OUT then IN; every further pair belongs to one generic endpoint, again OUT then IN. The endpoint engine drives single-cycle event pulses into the block. A flag is set by a byte-count-reached-zero event, by a software skip, by a successful SETUP (endpoint 0 OUT only), by a hardware clear of a generic endpoint's active bit, or by a transmitted NAK when the matching NAK-interrupt enable is on.

Software clears flags by writing ones to the status location. It programs a per-flag enable mask through a second location on the same write port. The combined interrupt output is high whenever any flag is set and also enabled by its mask bit. Reads of the status and mask outputs have no side effects. When a hardware set and a software clear hit the same flag in the same cycle, the set wins, so no event is lost.

Top module: `usb_ep_irq_status`

## Requirements
- R1: The status vector is 2+2*N_GEN_EP bits wide. Bit 0 is endpoint 0 OUT and bit 1 is endpoint 0 IN. For generic endpoint k (k=1..N_GEN_EP), bit 2k is OUT and bit 2k+1 is IN.
- R2: Bit 0 is set one clock after a pulse on ep0_out_cnt_zero, ep0_out_skip or ep0_setup_ok.
- R3: Bit 1 is set one clock after a pulse on ep0_in_cnt_zero or ep0_in_skip. A SETUP pulse never sets bit 1.
- R4: A pulse on bit k-1 of gen_out_done or gen_in_done sets the OUT or IN bit of generic endpoint k one clock later.
- R5: A NAK pulse sets its flag only while its enable is high. nak_en_ep0_out gates endpoint 0 OUT, nak_en_ep0_in gates endpoint 0 IN, nak_en_gen_out gates all generic OUT bits and nak_en_gen_in gates all generic IN bits. Any other enable has no effect on that flag.
- R6: A write with wr_sel=0 clears every status bit whose wr_data bit is one and leaves the bits written with zero unchanged.
- R7: If a set event and a write-one-to-clear hit the same bit in the same cycle, the bit is set after the clock.
- R8: While rst_n is low, status and irq_mask are all zeros and irq is low.
- R9: A write with wr_sel=1 loads wr_data into irq_mask. irq is high exactly when some bit is set in both status and irq_mask.
- R10: Status holds its value when no set event occurs and no status write is made. A mask write leaves status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ep0_out_cnt_zero | input | 1 | Endpoint 0 OUT byte count reached zero |
| ep0_out_skip | input | 1 | Software skip on endpoint 0 OUT |
| ep0_setup_ok | input | 1 | SETUP packet received on endpoint 0 |
| ep0_out_nak | input | 1 | NAK sent on endpoint 0 OUT |
| ep0_in_cnt_zero | input | 1 | Endpoint 0 IN byte count reached zero |
| ep0_in_skip | input | 1 | Software skip on endpoint 0 IN |
| ep0_in_nak | input | 1 | NAK sent on endpoint 0 IN |
| gen_out_done | input | N_GEN_EP | Active bit cleared by hardware, generic OUT endpoints |
| gen_in_done | input | N_GEN_EP | Active bit cleared by hardware, generic IN endpoints |
| gen_out_nak | input | N_GEN_EP | NAK sent, generic OUT endpoints |
| gen_in_nak | input | N_GEN_EP | NAK sent, generic IN endpoints |
| nak_en_ep0_out | input | 1 | NAK interrupt enable, endpoint 0 OUT |
| nak_en_ep0_in | input | 1 | NAK interrupt enable, endpoint 0 IN |
| nak_en_gen_out | input | 1 | NAK interrupt enable, all generic OUT |
| nak_en_gen_in | input | 1 | NAK interrupt enable, all generic IN |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 status clear, 1 mask |
| wr_data | input | 2+2*N_GEN_EP | Write data |
| status | output | 2+2*N_GEN_EP | Interrupt status flags |
| irq_mask | output | 2+2*N_GEN_EP | Interrupt enable mask |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with the default of four generic endpoints, so the status vector is ten bits wide. This puts the highest flag (endpoint 4 IN) in reach, and it lets one shared generic NAK enable act on several endpoints at once in a single vector. With four endpoints, an odd and an even endpoint can also be hit together to confirm the bit interleaving.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

    // Target of a bus write
    typedef enum logic {
        WSEL_STATUS = 1'b0,
        WSEL_MASK   = 1'b1
    } wsel_e;

    // Endpoint 0 event bundle
    typedef struct packed {
        logic out_cnt_zero;
        logic out_skip;
        logic setup_ok;
        logic out_nak;
        logic in_cnt_zero;
        logic in_skip;
        logic in_nak;
    } ep0_evt_t;

    // Shared NAK interrupt enables
    typedef struct packed {
        logic ep0_out;
        logic ep0_in;
        logic gen_out;
        logic gen_in;
    } nak_en_t;

    localparam int unsigned EP0_OUT_BIT = 0;
    localparam int unsigned EP0_IN_BIT  = 1;

    function automatic int unsigned gen_out_bit(input int unsigned idx);
        return 2 + 2 * idx;
    endfunction

    function automatic int unsigned gen_in_bit(input int unsigned idx);
        return 3 + 2 * idx;
    endfunction

endpackage

// File: rtl/usb_irq_set_gen.sv
module usb_irq_set_gen
    import usb_irq_pkg::*;
#(
    parameter int unsigned N_GEN_EP = 4,
    localparam int unsigned W       = 2 + 2 * N_GEN_EP
) (
    input  ep0_evt_t            ep0_evt,
    input  nak_en_t             nak_en,
    input  logic [N_GEN_EP-1:0] gen_out_done,
    input  logic [N_GEN_EP-1:0] gen_in_done,
    input  logic [N_GEN_EP-1:0] gen_out_nak,
    input  logic [N_GEN_EP-1:0] gen_in_nak,
    output logic [W-1:0]        set_vec
);

    logic ep0_out_set;
    logic ep0_in_set;

    always_comb begin
        ep0_out_set = ep0_evt.out_cnt_zero | ep0_evt.out_skip | ep0_evt.setup_ok
                    | (ep0_evt.out_nak & nak_en.ep0_out);
        ep0_in_set  = ep0_evt.in_cnt_zero | ep0_evt.in_skip
                    | (ep0_evt.in_nak & nak_en.ep0_in);
    end

    assign set_vec[EP0_OUT_BIT] = ep0_out_set;
    assign set_vec[EP0_IN_BIT]  = ep0_in_set;

    for (genvar k = 0; k < N_GEN_EP; k++) begin : g_gen
        assign set_vec[gen_out_bit(k)] = gen_out_done[k] | (gen_out_nak[k] & nak_en.gen_out);
        assign set_vec[gen_in_bit(k)]  = gen_in_done[k]  | (gen_in_nak[k]  & nak_en.gen_in);
    end

endmodule

// File: rtl/usb_irq_w1c_bank.sv
module usb_irq_w1c_bank #(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] flags
);

    typedef struct packed {
        logic [W-1:0] flags;
    } bank_t;

    bank_t st_d, st_q;

    // Set has priority over clear so a coincident event is kept
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < W; i++) begin
            if (set_vec[i]) begin
                st_d.flags[i] = 1'b1;
            end else if (clr_vec[i]) begin
                st_d.flags[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.flags;

endmodule

// File: rtl/usb_irq_mask_reg.sv
module usb_irq_mask_reg #(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] flags,
    output logic [W-1:0] mask,
    output logic         irq
);

    typedef struct packed {
        logic [W-1:0] mask;
    } mreg_t;

    mreg_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (load) begin
            m_d.mask = load_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign mask = m_q.mask;
    assign irq  = |(flags & m_q.mask);

endmodule

// File: rtl/usb_ep_irq_status.sv
module usb_ep_irq_status
    import usb_irq_pkg::*;
#(
    parameter int unsigned N_GEN_EP = 4,
    localparam int unsigned W       = 2 + 2 * N_GEN_EP
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ep0_out_cnt_zero,
    input  logic                ep0_out_skip,
    input  logic                ep0_setup_ok,
    input  logic                ep0_out_nak,
    input  logic                ep0_in_cnt_zero,
    input  logic                ep0_in_skip,
    input  logic                ep0_in_nak,
    input  logic [N_GEN_EP-1:0] gen_out_done,
    input  logic [N_GEN_EP-1:0] gen_in_done,
    input  logic [N_GEN_EP-1:0] gen_out_nak,
    input  logic [N_GEN_EP-1:0] gen_in_nak,
    input  logic                nak_en_ep0_out,
    input  logic                nak_en_ep0_in,
    input  logic                nak_en_gen_out,
    input  logic                nak_en_gen_in,
    input  logic                wr_en,
    input  logic                wr_sel,
    input  logic [W-1:0]        wr_data,
    output logic [W-1:0]        status,
    output logic [W-1:0]        irq_mask,
    output logic                irq
);

    ep0_evt_t     ep0_evt;
    nak_en_t      nak_en;
    logic [W-1:0] set_vec;
    logic [W-1:0] clr_vec;
    logic         mask_load;

    always_comb begin
        ep0_evt.out_cnt_zero = ep0_out_cnt_zero;
        ep0_evt.out_skip     = ep0_out_skip;
        ep0_evt.setup_ok     = ep0_setup_ok;
        ep0_evt.out_nak      = ep0_out_nak;
        ep0_evt.in_cnt_zero  = ep0_in_cnt_zero;
        ep0_evt.in_skip      = ep0_in_skip;
        ep0_evt.in_nak       = ep0_in_nak;
        nak_en.ep0_out       = nak_en_ep0_out;
        nak_en.ep0_in        = nak_en_ep0_in;
        nak_en.gen_out       = nak_en_gen_out;
        nak_en.gen_in        = nak_en_gen_in;
    end

    always_comb begin
        clr_vec   = (wr_en && wsel_e'(wr_sel) == WSEL_STATUS) ? wr_data : '0;
        mask_load = wr_en && wsel_e'(wr_sel) == WSEL_MASK;
    end

    usb_irq_set_gen #(.N_GEN_EP(N_GEN_EP)) u_set (
        .ep0_evt      (ep0_evt),
        .nak_en       (nak_en),
        .gen_out_done (gen_out_done),
        .gen_in_done  (gen_in_done),
        .gen_out_nak  (gen_out_nak),
        .gen_in_nak   (gen_in_nak),
        .set_vec      (set_vec)
    );

    usb_irq_w1c_bank #(.W(W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flags   (status)
    );

    usb_irq_mask_reg #(.W(W)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (mask_load),
        .load_val (wr_data),
        .flags    (status),
        .mask     (irq_mask),
        .irq      (irq)
    );

endmodule

// File: rtl/usb_ep_irq_status_chk.sv
module usb_ep_irq_status_chk #(
    parameter int unsigned N_GEN_EP = 4,
    localparam int unsigned W       = 2 + 2 * N_GEN_EP
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ep0_out_cnt_zero,
    input logic                ep0_out_skip,
    input logic                ep0_setup_ok,
    input logic                ep0_out_nak,
    input logic                ep0_in_cnt_zero,
    input logic                ep0_in_skip,
    input logic                ep0_in_nak,
    input logic [N_GEN_EP-1:0] gen_out_done,
    input logic [N_GEN_EP-1:0] gen_in_done,
    input logic [N_GEN_EP-1:0] gen_out_nak,
    input logic [N_GEN_EP-1:0] gen_in_nak,
    input logic                nak_en_ep0_out,
    input logic                nak_en_ep0_in,
    input logic                nak_en_gen_out,
    input logic                nak_en_gen_in,
    input logic                wr_en,
    input logic                wr_sel,
    input logic [W-1:0]        wr_data,
    input logic [W-1:0]        status,
    input logic [W-1:0]        irq_mask,
    input logic                irq
);

    logic any_evt;
    logic out0_src;
    logic clr0;

    assign out0_src = ep0_out_cnt_zero | ep0_out_skip | ep0_setup_ok
                    | (ep0_out_nak & nak_en_ep0_out);
    assign clr0     = wr_en & ~wr_sel & wr_data[0];
    assign any_evt  = ep0_out_cnt_zero | ep0_out_skip | ep0_setup_ok | ep0_out_nak
                    | ep0_in_cnt_zero | ep0_in_skip | ep0_in_nak
                    | (|gen_out_done) | (|gen_in_done) | (|gen_out_nak) | (|gen_in_nak);

    // R2
    a_r2_setup_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ep0_setup_ok |=> status[0]);

    // R3
    a_r3_in_skip_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ep0_in_skip |=> status[1]);

    // R4
    for (genvar k = 0; k < N_GEN_EP; k++) begin : g_chk
        a_r4_out_done: assert property (@(posedge clk) disable iff (!rst_n)
            gen_out_done[k] |=> status[2 + 2 * k]);
        a_r4_in_done: assert property (@(posedge clk) disable iff (!rst_n)
            gen_in_done[k] |=> status[3 + 2 * k]);
    end

    // R5
    a_r5_nak_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (ep0_out_nak && !nak_en_ep0_out && !ep0_out_cnt_zero && !ep0_out_skip
         && !ep0_setup_ok && !status[0]) |=> !status[0]);

    // R6
    a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (clr0 && !out0_src) |=> !status[0]);

    // R7
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr0 && out0_src) |=> status[0]);

    // R8
    a_r8_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (status == '0 && irq_mask == '0));

    // R9
    a_r9_no_mask_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask == '0) |-> !irq);

    // R10
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_evt && !(wr_en && !wr_sel)) |=> $stable(status));

endmodule

bind usb_ep_irq_status usb_ep_irq_status_chk #(.N_GEN_EP(N_GEN_EP)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .ep0_out_cnt_zero (ep0_out_cnt_zero),
    .ep0_out_skip     (ep0_out_skip),
    .ep0_setup_ok     (ep0_setup_ok),
    .ep0_out_nak      (ep0_out_nak),
    .ep0_in_cnt_zero  (ep0_in_cnt_zero),
    .ep0_in_skip      (ep0_in_skip),
    .ep0_in_nak       (ep0_in_nak),
    .gen_out_done     (gen_out_done),
    .gen_in_done      (gen_in_done),
    .gen_out_nak      (gen_out_nak),
    .gen_in_nak       (gen_in_nak),
    .nak_en_ep0_out   (nak_en_ep0_out),
    .nak_en_ep0_in    (nak_en_ep0_in),
    .nak_en_gen_out   (nak_en_gen_out),
    .nak_en_gen_in    (nak_en_gen_in),
    .wr_en            (wr_en),
    .wr_sel           (wr_sel),
    .wr_data          (wr_data),
    .status           (status),
    .irq_mask         (irq_mask),
    .irq              (irq)
);

// File: tb/sim_usb_ep_irq_status.sv
`timescale 1ns/1ps
module sim_usb_ep_irq_status;

    localparam int NG = 4;
    localparam int W  = 2 + 2 * NG;
    localparam int NV = 30;

    // c bits: [0] out cnt zero [1] out skip [2] setup [3] out nak
    //         [4] in cnt zero [5] in skip [6] in nak
    // en bits: [0] ep0 out [1] ep0 in [2] gen out [3] gen in
    typedef struct packed {
        logic [6:0]   c;
        logic [3:0]   go;
        logic [3:0]   gi;
        logic [3:0]   gon;
        logic [3:0]   gin;
        logic [3:0]   en;
        logic         we;
        logic         wa;
        logic [W-1:0] wd;
        logic [W-1:0] st;
        logic         iq;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{7'h01, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 10'h000, 10'h001, 1'b0}, // R2 cnt zero
        '{7'h00, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1, 1'b0, 10'h001, 10'h000, 1'b0}, // R6 clear
        '{7'h02, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 10'h000, 10'h001, 1'b0}, // R2 skip
        '{7'h04, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1, 1'b0, 10'h001, 10'h001, 1'b0}, // R7 set wins
        '{7'h00, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1, 1'b0, 10'h3FF, 10'h000, 1'b0}, // R6 clear all
        '{7'h10, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 10'h000, 10'h002, 1'b0}, // R3 cnt zero
        '{7'h20, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1, 1'b0, 10'h001, 10'h002, 1'b0}, // R6 zero leaves
        '{7'h00, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1, 1'b0, 10'h002, 10'h000, 1'b0}, // R6
        '{7'h04, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 10'h000, 10'h001, 1'b0}, // R3 setup not IN
        '{7'h00, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1, 1'b0, 10'h001, 10'h000, 1'b0}, // R6
        '{7'h00, 4'h1, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 10'h000, 10'h004, 1'b0}, // R4 EP1 OUT
        '{7'h00, 4'h0, 4'h8, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 10'h000, 10'h204, 1'b0}, // R1 EP4 IN
        '{7'h00, 4'h4, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 10'h000, 10'h244, 1'b0}, // R1 EP3 OUT
        '{7'h00, 4'h0, 4'h2, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 10'h000, 10'h264, 1'b0}, // R4 EP2 IN
        '{7'h00, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1, 1'b0, 10'h3FF, 10'h000, 1'b0}, // R6
        '{7'h08, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 10'h000, 10'h000, 1'b0}, // R5 nak off
        '{7'h08, 4'h0, 4'h0, 4'h0, 4'h0, 4'h1, 1'b0, 1'b0, 10'h000, 10'h001, 1'b0}, // R5 nak on
        '{7'h40, 4'h0, 4'h0, 4'h0, 4'h0, 4'h1, 1'b0, 1'b0, 10'h000, 10'h001, 1'b0}, // R5 wrong enable
        '{7'h40, 4'h0, 4'h0, 4'h0, 4'h0, 4'h2, 1'b0, 1'b0, 10'h000, 10'h003, 1'b0}, // R5
        '{7'h00, 4'h0, 4'h0, 4'hF, 4'h0, 4'h8, 1'b0, 1'b0, 10'h000, 10'h003, 1'b0}, // R5 wrong enable
        '{7'h00, 4'h0, 4'h0, 4'hA, 4'h0, 4'h4, 1'b0, 1'b0, 10'h000, 10'h113, 1'b0}, // R5 shared out
        '{7'h00, 4'h0, 4'h0, 4'h0, 4'h5, 4'h4, 1'b0, 1'b0, 10'h000, 10'h113, 1'b0}, // R5 wrong enable
        '{7'h00, 4'h0, 4'h0, 4'h0, 4'h5, 4'h8, 1'b0, 1'b0, 10'h000, 10'h19B, 1'b0}, // R5 shared in
        '{7'h00, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1, 1'b1, 10'h004, 10'h19B, 1'b0}, // R9 masked
        '{7'h00, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1, 1'b1, 10'h008, 10'h19B, 1'b1}, // R9 enabled
        '{7'h00, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1, 1'b0, 10'h008, 10'h193, 1'b0}, // R9 after clear
        '{7'h00, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 10'h000, 10'h193, 1'b0}, // R10 idle
        '{7'h00, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1, 1'b1, 10'h3FF, 10'h193, 1'b1}, // R10 mask write
        '{7'h00, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1, 1'b0, 10'h3FF, 10'h000, 1'b0}, // R9
        '{7'h00, 4'h1, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 10'h000, 10'h004, 1'b1}  // R9
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [6:0]    c = '0;
    logic [NG-1:0] go = '0, gi = '0, gon = '0, gin = '0;
    logic [3:0]    en = '0;
    logic          we = 1'b0, wa = 1'b0;
    logic [W-1:0]  wd = '0;
    logic [W-1:0]  status, irq_mask;
    logic          irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    usb_ep_irq_status #(.N_GEN_EP(NG)) u0 (
        .clk(clk), .rst_n(rst_n),
        .ep0_out_cnt_zero(c[0]), .ep0_out_skip(c[1]), .ep0_setup_ok(c[2]),
        .ep0_out_nak(c[3]), .ep0_in_cnt_zero(c[4]), .ep0_in_skip(c[5]),
        .ep0_in_nak(c[6]),
        .gen_out_done(go), .gen_in_done(gi), .gen_out_nak(gon), .gen_in_nak(gin),
        .nak_en_ep0_out(en[0]), .nak_en_ep0_in(en[1]),
        .nak_en_gen_out(en[2]), .nak_en_gen_in(en[3]),
        .wr_en(we), .wr_sel(wa), .wr_data(wd),
        .status(status), .irq_mask(irq_mask), .irq(irq)
    );

    task automatic check(input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        c = '0; go = '0; gi = '0; gon = '0; gin = '0; en = '0;
        we = 1'b0; wa = 1'b0; wd = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        repeat (3) @(negedge clk);
        check("R8 status in reset", status, '0);
        check("R8 mask in reset", irq_mask, '0);
        check("R8 irq in reset", W'(irq), '0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            c = VECS[i].c; go = VECS[i].go; gi = VECS[i].gi;
            gon = VECS[i].gon; gin = VECS[i].gin; en = VECS[i].en;
            we = VECS[i].we; wa = VECS[i].wa; wd = VECS[i].wd;
            @(negedge clk);
            check($sformatf("vector %0d status", i), status, VECS[i].st);
            check($sformatf("vector %0d irq", i), W'(irq), W'(VECS[i].iq));
        end
        idle_inputs();
        @(negedge clk);

        // R8: reset in mid-run clears status and mask
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 status after mid reset", status, '0);
        check("R8 mask after mid reset", irq_mask, '0);
        check("R8 irq after mid reset", W'(irq), '0);
        rst_n = 1'b1;

        // R9: mask reset keeps irq low although a flag is set
        go = 4'h1;
        @(negedge clk);
        idle_inputs();
        check("R9 flag set after reset", status, 10'h004);
        check("R9 irq held by reset mask", W'(irq), '0);

        // R10: mask load leaves status alone
        we = 1'b1; wa = 1'b1; wd = 10'h004;
        @(negedge clk);
        idle_inputs();
        check("R10 status across mask write", status, 10'h004);
        check("R9 mask loaded", irq_mask, 10'h004);
        check("R9 irq once enabled", W'(irq), 10'h001);

        // R7: top bit set and cleared together
        gi = 4'h8; we = 1'b1; wa = 1'b0; wd = 10'h200;
        @(negedge clk);
        idle_inputs();
        check("R7 set wins on EP4 IN", status, 10'h204);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule